// File: doc/BRIEF.md
# Reloadable Down-Counting Programmable Timer

This block is an 8-bit down counter. Software loads a start value into a reload register and selects what the counter counts. In timer mode it counts a prescaled clock. In event counter mode it counts an external event line. Both inputs are treated as slow signals. Each passes through a synchronizer into the system clock, and the counter acts on the edges that the synchronizer finds. On a falling edge of the selected input the counter steps down by one. When the counter leaves zero it raises a one-cycle interrupt. The value in the reload register then takes effect on the next rising edge of that input.

Software drives the block through a small register port. The control register holds the run, mode, one-shot and output-enable bits. A second register holds the reload value. The counter can be read back at any time. In continuous mode the counter keeps reloading and counting. In one-shot mode it reloads once and then stops. The timer output changes state on every underflow. It is forced low while the output enable is clear.

Top module: `prog_timer`

## Requirements
- R1: After reset the control register (address 0) reads 00h, so run=0 and timer mode is selected. The reload register (address 1) and the counter (address 2) read 00h, and irq_o and tout_o are low.
- R2: While run (control bit 0) is 1, each falling edge of the selected count input lowers the counter by one. The new value can be read after the third rising clk edge that follows the input's fall: two synchronizer flops, then the counter register.
- R3: A falling edge seen while the counter is 00h is an underflow. It drives irq_o high for exactly one clk cycle, and the counter reads FFh until the next rising edge of the count input.
- R4: After an underflow, the next rising edge of the count input loads the reload register into the counter. In continuous mode (control bit 2 = 0) counting then goes on from that value.
- R5: With control bit 1 = 0 only tick_i is counted. With control bit 1 = 1 only event_i is counted. Edges on the input that is not selected leave the counter unchanged.
- R6: With run = 0 the counter holds its value through any count edge. Setting run to 1 again resumes counting from the held value.
- R7: In one-shot mode (control bit 2 = 1) an underflow clears run. The counter still loads the reload value on the following rising edge, and it holds that value through later count edges.
- R8: While control bit 3 is 1, tout_o changes state on every underflow. While bit 3 is 0, tout_o is low.
- R9: If a write to the reload register falls in the same clk cycle in which a pending reload takes effect, the counter receives the value being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaled count clock (timer mode) |
| event_i | input | 1 | External event input (event counter mode) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 reload |
| wr_data_i | input | CNT_W | Write data |
| rd_addr_i | input | 2 | Read address: 0 control, 1 reload, 2 counter |
| rd_data_o | output | CNT_W | Read data, combinational from rd_addr_i |
| irq_o | output | 1 | One-cycle underflow interrupt |
| tout_o | output | 1 | Timer output, gated by the output enable |

## Verification
A pending reload commits on a rising edge of the count input. A software write to the reload register can land on that very clk cycle. The bench forces this case on purpose: it raises the count input and counts the synchronizer cycles so that the write strobe sits exactly on the commit cycle. It then checks that the counter holds the freshly written value and not the old one. The random phase writes registers only between complete count pulses, so the reference model's timing never overlaps with the commit window.

// File: rtl/pt_pkg.sv
package pt_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        PT_A_CTRL   = 2'd0,
        PT_A_RELOAD = 2'd1,
        PT_A_COUNT  = 2'd2,
        PT_A_SPARE  = 2'd3
    } pt_addr_e;

    // control register bit positions
    localparam int CB_RUN = 0;
    localparam int CB_EVT = 1;
    localparam int CB_ONE = 2;
    localparam int CB_OE  = 3;
    localparam int CB_NUM = 4;
endpackage

// File: rtl/pt_edge_sync.sv
module pt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic fall_o,
    output logic rise_o
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LEN-2:0], sig_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // previous synchronized sample against current synchronized sample
    assign fall_o =  sh_q[LEN-1] & ~sh_q[LEN-2];
    assign rise_o = ~sh_q[LEN-1] &  sh_q[LEN-2];
endmodule

// File: rtl/pt_core.sv
module pt_core
    import pt_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_fall,
    input  logic              cnt_rise,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    output logic [CW-1:0]     cnt_o,
    output logic [CW-1:0]     reload_o,
    output logic              run_o,
    output logic              evmode_o,
    output logic              oneshot_o,
    output logic              oe_o,
    output logic              irq_o,
    output logic              tout_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] reload;
        logic          run;
        logic          evmode;
        logic          oneshot;
        logic          oe;
        logic          pend;
        logic          irq;
        logic          tout;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;

        if (cnt_fall && st_q.run) begin
            if (st_q.cnt == '0) begin
                st_d.cnt  = '1;
                st_d.irq  = 1'b1;
                st_d.pend = 1'b1;
                st_d.tout = ~st_q.tout;
                if (st_q.oneshot) st_d.run = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end

        if (wr_en) begin
            case (pt_addr_e'(wr_addr))
                PT_A_CTRL: begin
                    st_d.run     = wr_data[CB_RUN];
                    st_d.evmode  = wr_data[CB_EVT];
                    st_d.oneshot = wr_data[CB_ONE];
                    st_d.oe      = wr_data[CB_OE];
                end
                PT_A_RELOAD: st_d.reload = wr_data;
                default: ;
            endcase
        end

        // commit uses the reload value after this cycle's write
        if (cnt_rise && st_q.pend) begin
            st_d.cnt  = st_d.reload;
            st_d.pend = 1'b0;
        end

        if (!st_q.oe) st_d.tout = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o     = st_q.cnt;
    assign reload_o  = st_q.reload;
    assign run_o     = st_q.run;
    assign evmode_o  = st_q.evmode;
    assign oneshot_o = st_q.oneshot;
    assign oe_o      = st_q.oe;
    assign irq_o     = st_q.irq;
    assign tout_o    = st_q.tout;
endmodule

// File: rtl/prog_timer.sv
module prog_timer
    import pt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              event_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [CNT_W-1:0]  rd_data_o,
    output logic              irq_o,
    output logic              tout_o
);
    localparam int NSRC = 2;

    logic [NSRC-1:0] src_v, fall_v, rise_v;
    logic            sel_fall, sel_rise;
    logic [CNT_W-1:0] cnt, reload, ctrl_rd;
    logic            run, evmode, oneshot, oe, tout_raw;

    assign src_v = {event_i, tick_i};

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        pt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_i  (src_v[g]),
            .fall_o (fall_v[g]),
            .rise_o (rise_v[g])
        );
    end

    assign sel_fall = evmode ? fall_v[1] : fall_v[0];
    assign sel_rise = evmode ? rise_v[1] : rise_v[0];

    pt_core #(.CW(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_fall  (sel_fall),
        .cnt_rise  (sel_rise),
        .wr_en     (wr_en_i),
        .wr_addr   (wr_addr_i),
        .wr_data   (wr_data_i),
        .cnt_o     (cnt),
        .reload_o  (reload),
        .run_o     (run),
        .evmode_o  (evmode),
        .oneshot_o (oneshot),
        .oe_o      (oe),
        .irq_o     (irq_o),
        .tout_o    (tout_raw)
    );

    always_comb begin
        ctrl_rd         = '0;
        ctrl_rd[CB_RUN] = run;
        ctrl_rd[CB_EVT] = evmode;
        ctrl_rd[CB_ONE] = oneshot;
        ctrl_rd[CB_OE]  = oe;
    end

    always_comb begin
        case (pt_addr_e'(rd_addr_i))
            PT_A_CTRL:   rd_data_o = ctrl_rd;
            PT_A_RELOAD: rd_data_o = reload;
            PT_A_COUNT:  rd_data_o = cnt;
            default:     rd_data_o = '0;
        endcase
    end

    // output gate is not retimed to the enable bit
    assign tout_o = tout_raw & oe;
endmodule

// File: rtl/pt_checker.sv
module pt_checker
    import pt_pkg::*;
#(
    parameter int CW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fall,
    input logic              rise,
    input logic              run,
    input logic              oneshot,
    input logic              oe,
    input logic              irq,
    input logic              tout,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CW-1:0]     cnt
);
    logic wr_ctrl;
    assign wr_ctrl = wr_en && (wr_addr == PT_A_CTRL);

    AST_DEC_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fall && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R2

    AST_IRQ_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fall && cnt == '0) |=> (irq && cnt == '1)); // R3

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R3

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !rise) |=> $stable(cnt)); // R6

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (oneshot && run && fall && cnt == '0 && !wr_ctrl) |=> !run); // R7

    AST_TOUT_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && $past(oe) && tout != $past(tout)) |-> irq); // R8
endmodule

bind prog_timer pt_checker #(.CW(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fall    (sel_fall),
    .rise    (sel_rise),
    .run     (run),
    .oneshot (oneshot),
    .oe      (oe),
    .irq     (irq_o),
    .tout    (tout_o),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .cnt     (cnt)
);

// File: tb/prog_timer_tb.sv
module prog_timer_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b1;
    logic       event_i = 1'b1;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [1:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic       irq_o, tout_o;

    int n_chk = 0, n_fail = 0, irq_seen = 0, m_irq = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0] m_cnt, m_rel;
    logic m_run, m_evt, m_one, m_oe, m_pend, m_tout;

    always #(CLK_P/2) clk = ~clk;

    prog_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .event_i(event_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .irq_o(irq_o), .tout_o(tout_o)
    );

    always @(negedge clk) if (rst_n && irq_o) irq_seen++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr_i = a;
        #1 v = rd_data_o;
    endtask

    function automatic logic [7:0] ctrl_word();
        return {4'b0, m_oe, m_one, m_evt, m_run};
    endfunction

    function automatic void model_fall();
        if (m_run) begin
            if (m_cnt == 8'h00) begin
                m_cnt = 8'hFF; m_irq++; m_pend = 1'b1;
                if (m_oe) m_tout = ~m_tout;
                if (m_one) m_run = 1'b0;
            end else m_cnt = m_cnt - 8'd1;
        end
    endfunction

    function automatic void model_rise();
        if (m_pend) begin m_cnt = m_rel; m_pend = 1'b0; end
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
        if (a == 2'd0) begin
            m_run = d[0]; m_evt = d[1]; m_one = d[2]; m_oe = d[3];
            if (!m_oe) m_tout = 1'b0;
        end else if (a == 2'd1) m_rel = d;
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        rd(2'd2, v); chk({req, " counter"}, v, m_cnt);
        rd(2'd0, v); chk({req, " ctrl"}, v, ctrl_word());
        chk({req, " irq count"}, irq_seen, m_irq);
        chk({req, " tout"}, tout_o, m_tout & m_oe);
    endtask

    task automatic drive_src(input bit ev, input logic val);
        if (ev) event_i = val; else tick_i = val;
    endtask

    task automatic fall_half(input bit ev, input string req);
        @(negedge clk); drive_src(ev, 1'b0);
        repeat (4) @(posedge clk);
        if (ev == m_evt) model_fall();
        @(negedge clk); check_all(req);
    endtask

    task automatic rise_half(input bit ev, input string req);
        @(negedge clk); drive_src(ev, 1'b1);
        repeat (4) @(posedge clk);
        if (ev == m_evt) model_rise();
        @(negedge clk); check_all(req);
    endtask

    task automatic pulse(input bit ev, input string req);
        fall_half(ev, req);
        rise_half(ev, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5EED_0042));
        m_cnt = 0; m_rel = 0; m_run = 0; m_evt = 0; m_one = 0;
        m_oe = 0; m_pend = 0; m_tout = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd1, v); chk("R1 reload", v, 8'h00);
        rd(2'd2, v); chk("R1 counter", v, 8'h00);
        chk("R1 irq", irq_o, 1'b0);
        chk("R1 tout", tout_o, 1'b0);

        // R2 R3 R4 R8: continuous timer mode, reload 03h, output enabled
        wr(2'd1, 8'h03);
        wr(2'd0, 8'h09);
        for (int i = 0; i < 10; i++) pulse(1'b0, "R2 R3 R4 R8 continuous");

        // R6: stop holds, resume continues
        wr(2'd0, 8'h08);
        for (int i = 0; i < 3; i++) pulse(1'b0, "R6 stopped hold");
        wr(2'd0, 8'h09);
        pulse(1'b0, "R6 resume");

        // R5: event mode ignores tick_i, counts event_i
        wr(2'd0, 8'h0B);
        for (int i = 0; i < 2; i++) pulse(1'b0, "R5 tick ignored in event mode");
        for (int i = 0; i < 5; i++) pulse(1'b1, "R5 event counted");
        wr(2'd0, 8'h09);
        pulse(1'b1, "R5 event ignored in timer mode");

        // R8: output enable low forces tout low
        wr(2'd0, 8'h01);
        for (int i = 0; i < 6; i++) pulse(1'b0, "R8 tout gated");

        // R7: one-shot
        wr(2'd1, 8'h02);
        wr(2'd0, 8'h0D);
        for (int i = 0; i < 8; i++) pulse(1'b0, "R7 one-shot");
        chk("R7 run cleared", m_run, 1'b0);

        // R9: reload write in the commit cycle
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h09);
        for (int i = 0; i < 300 && !m_pend; i++) begin
            fall_half(1'b0, "R9 setup");
            if (!m_pend) rise_half(1'b0, "R9 setup");
        end
        @(negedge clk); tick_i = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 8'h5A;
        @(negedge clk); wr_en_i = 1'b0;
        m_rel = 8'h5A; model_rise();
        repeat (2) @(negedge clk);
        rd(2'd2, v); chk("R9 commit takes written value", v, 8'h5A);
        check_all("R9");

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            int op = $urandom % 10;
            if (op == 0) wr(2'd1, 8'($urandom % 8));
            else if (op == 1) wr(2'd0, {4'b0, 4'($urandom) | ((($urandom % 4) != 0) ? 4'h1 : 4'h0)});
            else pulse((($urandom % 4) == 0) ? ~m_evt : m_evt, "R2 R4 R5 random");
        end

        finish_run();
    end
endmodule